// File: doc/BRIEF.md
# Redundant Energy Frame Relay

The relay listens to two redundant serial feeds of beam-energy frames. Each frame is 32 bits long and carries a fixed header, a 16-bit energy value, a toggle bit and a 4-bit CRC. Only one feed is active at a time. Every frame that completes on the active feed is checked. Good frames are counted. Faulty frames, or silence on the active feed, are counted and move the relay to the other feed.

When a good frame carries a new value, the relay turns the 16-bit energy into a 5-bit code. In test mode the host's code is used in its place. The relay then re-frames the code together with the host's test-command bits and broadcasts the new frame, one bit per cycle, to every receiver lane at once. Two watchdogs run alongside. One flags a missing frame and one flags an energy value that has gone stale.

Top module: `energy_frame_relay`

## Requirements
- R1: A frame enters as 32 bits, MSB first, one bit per cycle in which that feed's `*_vld` is high, and starts with the bit that carries `*_sof`. It is good only if bits 31:24 equal 8'h90, bits 6:4 are zero, and bits 3:0 equal the CRC-4 (polynomial x^4+x+1, initial value 0, MSB first) of bits 31:4. Bits 23:8 hold the energy and bit 7 holds the toggle.
- R2: A frame on the active feed that fails R1 increments `cnt_bad`, leaves `code` unchanged, sends nothing and moves the relay to the other feed.
- R3: Each good frame on the active feed increments `cnt_good` by one. All counters saturate.
- R4: For a new value outside test mode, `code` becomes the largest k in 0..31 with 64·k·k ≤ energy.
- R5: While `test_mode` is high, a new value loads `code` from `test_code` instead of the table.
- R6: A good frame counts as a new value if it is the first since reset or if its toggle differs from the last accepted toggle. Otherwise it increments `cnt_rep`, leaves `code` unchanged and sends nothing.
- R7: After FRAME_TMO cycles with neither a good frame nor a feed change, `frm_tmo` is set, `cnt_lost` is incremented and the relay moves to the other feed. The next good frame clears `frm_tmo`. If a good frame completes in the same cycle as the expiry, the good frame wins and no timeout occurs.
- R8: After VALUE_TMO cycles without a new value, `nrg_tmo` is set. The next new value clears it.
- R9: After reset the relay uses feed A (`act_b`=0). Frames on the standby feed have no effect on any output.
- R10: For each new value, an outgoing frame starts in the next cycle. It is 32 bits, MSB first, one bit per cycle, with `tx_sof` on the first bit. It holds header 8'h90, `test_cmd` in bits 23:13, `code` in bits 12:8, the incoming toggle in bit 7, zeros in bits 6:4 and a freshly computed CRC. The same bit appears on every lane of `tx_dat`.
- R11: During reset all counters, `code`, `frm_tmo`, `nrg_tmo`, `act_b` and `tx_vld` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_vld | input | 1 | Feed A bit strobe |
| a_sof | input | 1 | Feed A first bit of a frame |
| a_dat | input | 1 | Feed A serial data |
| b_vld | input | 1 | Feed B bit strobe |
| b_sof | input | 1 | Feed B first bit of a frame |
| b_dat | input | 1 | Feed B serial data |
| test_mode | input | 1 | Use the host code instead of the table |
| test_code | input | 5 | Host substitute code |
| test_cmd | input | 11 | Test-command bits placed in the outgoing payload |
| act_b | output | 1 | 1 when feed B is active |
| code | output | 5 | Last energy code |
| frm_tmo | output | 1 | Frame timeout flag |
| nrg_tmo | output | 1 | Stale-value flag |
| cnt_good | output | CNT_W | Good frames |
| cnt_bad | output | CNT_W | Rejected frames |
| cnt_lost | output | CNT_W | Frame timeouts |
| cnt_rep | output | CNT_W | Frames with a repeated toggle |
| tx_vld | output | 1 | Outgoing bit valid |
| tx_sof | output | 1 | Outgoing first bit |
| tx_dat | output | N_RX | Outgoing bit, the same on every lane |

## Verification
A frame can complete on the active feed in the very cycle in which the frame watchdog expires. The bench provokes this by placing the next frame's last bit exactly FRAME_TMO cycles after the previous acceptance. It then checks that the frame is counted, that `cnt_lost` and `frm_tmo` stay at zero and that the feed does not change. The same frame sent one cycle later must lose instead: a timeout is counted, the feed changes, and the late frame, now on the standby feed, is ignored.

// File: rtl/efr_pkg.sv
package efr_pkg;
    localparam int FRAME_W = 32;
    localparam int CODE_W  = 5;
    localparam int CMD_W   = 16 - CODE_W;
    localparam logic [7:0] HDR = 8'h90;

    typedef struct packed {
        logic [FRAME_W-2:0] sh;
        logic [5:0]         cnt;
    } rx_state_t;

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [5:0]         left;
    } tx_state_t;

    // CRC-4, x^4+x+1, initial value zero, message MSB first
    function automatic logic [3:0] crc4(input logic [FRAME_W-5:0] m);
        logic [3:0] c;
        logic       fb;
        c = 4'h0;
        for (int i = FRAME_W - 5; i >= 0; i--) begin
            fb = c[3] ^ m[i];
            c  = {c[2:0], 1'b0};
            if (fb) c = c ^ 4'b0011;
        end
        return c;
    endfunction

    // quadratic breakpoints: count of k in 1..31 with energy >= 64*k*k
    function automatic logic [CODE_W-1:0] nrg_code(input logic [15:0] e);
        logic [CODE_W-1:0] c;
        c = '0;
        for (int k = 1; k < 32; k++)
            if (int'(e) >= k * k * 64) c = c + 1'b1;
        return c;
    endfunction
endpackage

// File: rtl/efr_rx.sv
module efr_rx
    import efr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vld,
    input  logic               sof,
    input  logic               dat,
    output logic               done,
    output logic [FRAME_W-1:0] word
);
    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (vld && sof) begin
            st_d.sh  = {{(FRAME_W-2){1'b0}}, dat};
            st_d.cnt = 6'd1;
        end else if (vld && st_q.cnt != 6'd0) begin
            if (st_q.cnt == 6'(FRAME_W - 1)) begin
                done     = 1'b1;
                st_d.cnt = 6'd0;
            end else begin
                st_d.sh  = {st_q.sh[FRAME_W-3:0], dat};
                st_d.cnt = st_q.cnt + 6'd1;
            end
        end
        word = {st_q.sh, dat};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/efr_chk.sv
module efr_chk
    import efr_pkg::*;
(
    input  logic [FRAME_W-1:0] word,
    output logic               ok
);
    always_comb begin
        ok = (word[31:24] == HDR) && (word[6:4] == 3'b000) &&
             (word[3:0] == crc4(word[31:4]));
    end
endmodule

// File: rtl/efr_tx.sv
module efr_tx
    import efr_pkg::*;
#(
    parameter int N_RX = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] word,
    output logic               tx_vld,
    output logic               tx_sof,
    output logic [N_RX-1:0]    tx_dat
);
    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sh   = word;
            st_d.left = 6'(FRAME_W);
        end else if (st_q.left != 6'd0) begin
            st_d.sh   = {st_q.sh[FRAME_W-2:0], 1'b0};
            st_d.left = st_q.left - 6'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_vld = (st_q.left != 6'd0);
    assign tx_sof = (st_q.left == 6'(FRAME_W));

    for (genvar i = 0; i < N_RX; i++) begin : g_lane
        assign tx_dat[i] = st_q.sh[FRAME_W-1] & tx_vld;
    end
endmodule

// File: rtl/energy_frame_relay.sv
module energy_frame_relay
    import efr_pkg::*;
#(
    parameter int N_RX      = 16,
    parameter int CNT_W     = 16,
    parameter int FRAME_TMO = 40000,
    parameter int VALUE_TMO = 40000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_vld,
    input  logic              a_sof,
    input  logic              a_dat,
    input  logic              b_vld,
    input  logic              b_sof,
    input  logic              b_dat,
    input  logic              test_mode,
    input  logic [CODE_W-1:0] test_code,
    input  logic [CMD_W-1:0]  test_cmd,
    output logic              act_b,
    output logic [CODE_W-1:0] code,
    output logic              frm_tmo,
    output logic              nrg_tmo,
    output logic [CNT_W-1:0]  cnt_good,
    output logic [CNT_W-1:0]  cnt_bad,
    output logic [CNT_W-1:0]  cnt_lost,
    output logic [CNT_W-1:0]  cnt_rep,
    output logic              tx_vld,
    output logic              tx_sof,
    output logic [N_RX-1:0]   tx_dat
);
    localparam int FT_W = $clog2(FRAME_TMO + 1);
    localparam int VT_W = $clog2(VALUE_TMO + 1);
    localparam logic [FT_W-1:0] FT_LAST = FT_W'(FRAME_TMO - 1);
    localparam logic [VT_W-1:0] VT_LAST = VT_W'(VALUE_TMO - 1);

    typedef struct packed {
        logic              act;
        logic              ftmo;
        logic              ntmo;
        logic              have_tog;
        logic              last_tog;
        logic [CODE_W-1:0] code;
        logic [FT_W-1:0]   ftmr;
        logic [VT_W-1:0]   vtmr;
        logic [CNT_W-1:0]  good;
        logic [CNT_W-1:0]  bad;
        logic [CNT_W-1:0]  lost;
        logic [CNT_W-1:0]  rep;
    } st_t;

    st_t st_d, st_q;

    logic [1:0]         vld_w, sof_w, dat_w, done_w, ok_w;
    logic [FRAME_W-1:0] word_w [2];

    assign vld_w = {b_vld, a_vld};
    assign sof_w = {b_sof, a_sof};
    assign dat_w = {b_dat, a_dat};

    for (genvar ch = 0; ch < 2; ch++) begin : g_feed
        efr_rx u_rx (
            .clk  (clk),
            .rst_n(rst_n),
            .vld  (vld_w[ch]),
            .sof  (sof_w[ch]),
            .dat  (dat_w[ch]),
            .done (done_w[ch]),
            .word (word_w[ch])
        );
        efr_chk u_chk (
            .word(word_w[ch]),
            .ok  (ok_w[ch])
        );
    end

    logic               good_w, bad_w, tmo_w, newv_w, tog_w;
    logic [FRAME_W-1:0] sel_w, txw_w;
    logic [CODE_W-1:0]  ncode_w;
    logic [FRAME_W-5:0] txbody_w;

    always_comb begin
        sel_w    = word_w[st_q.act];
        good_w   = done_w[st_q.act] && ok_w[st_q.act];
        bad_w    = done_w[st_q.act] && !ok_w[st_q.act];
        tmo_w    = !done_w[st_q.act] && (st_q.ftmr == FT_LAST);
        tog_w    = sel_w[7];
        newv_w   = good_w && (!st_q.have_tog || tog_w != st_q.last_tog);
        ncode_w  = test_mode ? test_code : nrg_code(sel_w[23:8]);
        txbody_w = {HDR, test_cmd, ncode_w, tog_w, 3'b000};
        txw_w    = {txbody_w, crc4(txbody_w)};

        st_d = st_q;
        if (good_w) begin
            if (!(&st_q.good)) st_d.good = st_q.good + 1'b1;
            st_d.ftmo = 1'b0;
            st_d.ftmr = '0;
        end else if (bad_w) begin
            if (!(&st_q.bad)) st_d.bad = st_q.bad + 1'b1;
            st_d.act  = !st_q.act;
            st_d.ftmr = '0;
        end else if (tmo_w) begin
            if (!(&st_q.lost)) st_d.lost = st_q.lost + 1'b1;
            st_d.ftmo = 1'b1;
            st_d.act  = !st_q.act;
            st_d.ftmr = '0;
        end else begin
            st_d.ftmr = st_q.ftmr + 1'b1;
        end

        if (newv_w) begin
            st_d.have_tog = 1'b1;
            st_d.last_tog = tog_w;
            st_d.code     = ncode_w;
            st_d.vtmr     = '0;
            st_d.ntmo     = 1'b0;
        end else if (st_q.vtmr == VT_LAST) begin
            st_d.ntmo = 1'b1;
            st_d.vtmr = '0;
        end else begin
            st_d.vtmr = st_q.vtmr + 1'b1;
        end

        if (good_w && !newv_w && !(&st_q.rep)) st_d.rep = st_q.rep + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    efr_tx #(.N_RX(N_RX)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (newv_w),
        .word  (txw_w),
        .tx_vld(tx_vld),
        .tx_sof(tx_sof),
        .tx_dat(tx_dat)
    );

    assign act_b    = st_q.act;
    assign code     = st_q.code;
    assign frm_tmo  = st_q.ftmo;
    assign nrg_tmo  = st_q.ntmo;
    assign cnt_good = st_q.good;
    assign cnt_bad  = st_q.bad;
    assign cnt_lost = st_q.lost;
    assign cnt_rep  = st_q.rep;

    // R2 R7
    feed_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_b != $past(act_b)) |-> (cnt_bad != $past(cnt_bad)) || (cnt_lost != $past(cnt_lost))
                                    || (&$past(cnt_bad)) || (&$past(cnt_lost)));
    // R3
    good_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_good - $past(cnt_good)) <= CNT_W'(1));
    // R9
    good_keeps_feed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_good != $past(cnt_good)) |-> (act_b == $past(act_b)));
    // R7
    lost_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_tmo) |-> (cnt_lost != $past(cnt_lost)) || (&$past(cnt_lost)));
    // R5
    subst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(test_mode) && code != $past(code)) |-> (code == $past(test_code)));
    // R8
    stale_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nrg_tmo) |-> (code == $past(code)));
    // R10
    tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_vld) |-> tx_sof);
endmodule

// File: tb/energy_frame_relay_bench.sv
module energy_frame_relay_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_RX  = 16;
    localparam int CNT_W = 16;
    localparam int FTMO  = 40;
    localparam int VTMO  = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_vld = 0, a_sof = 0, a_dat = 0, b_vld = 0, b_sof = 0, b_dat = 0;
    logic test_mode = 0;
    logic [4:0]  test_code = 5'd0;
    logic [10:0] test_cmd = 11'h5A3;
    logic act_b, frm_tmo, nrg_tmo, tx_vld, tx_sof;
    logic [4:0] code;
    logic [CNT_W-1:0] cnt_good, cnt_bad, cnt_lost, cnt_rep;
    logic [N_RX-1:0] tx_dat;

    always #(CLK_PERIOD/2) clk = ~clk;

    energy_frame_relay #(.N_RX(N_RX), .CNT_W(CNT_W), .FRAME_TMO(FTMO), .VALUE_TMO(VTMO))
    u_energy_frame_relay (
        .clk(clk), .rst_n(rst_n),
        .a_vld(a_vld), .a_sof(a_sof), .a_dat(a_dat),
        .b_vld(b_vld), .b_sof(b_sof), .b_dat(b_dat),
        .test_mode(test_mode), .test_code(test_code), .test_cmd(test_cmd),
        .act_b(act_b), .code(code), .frm_tmo(frm_tmo), .nrg_tmo(nrg_tmo),
        .cnt_good(cnt_good), .cnt_bad(cnt_bad), .cnt_lost(cnt_lost), .cnt_rep(cnt_rep),
        .tx_vld(tx_vld), .tx_sof(tx_sof), .tx_dat(tx_dat)
    );

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];

    // model state
    int m_good = 0, m_bad = 0, m_lost = 0, m_rep = 0, m_act = 0, m_code = 0;

    function automatic logic [3:0] ref_crc(input logic [27:0] m);
        logic [31:0] r;
        r = {m, 4'b0000};
        for (int i = 31; i >= 4; i--)
            if (r[i]) r[i -: 5] = r[i -: 5] ^ 5'b10011;
        return r[3:0];
    endfunction

    function automatic int ref_code(input logic [15:0] e);
        for (int k = 31; k >= 0; k--)
            if (k * k * 64 <= int'(e)) return k;
        return 0;
    endfunction

    function automatic logic [31:0] mk(input logic [15:0] e, input logic t);
        logic [27:0] b;
        b = {8'h90, e, t, 3'b000};
        return {b, ref_crc(b)};
    endfunction

    function automatic logic [31:0] mk_tx(input int c, input logic t);
        logic [27:0] b;
        b = {8'h90, test_cmd, 5'(c), t, 3'b000};
        return {b, ref_crc(b)};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input int ftmo, input int ntmo);
        check({tag, " cnt_good"}, int'(cnt_good), m_good);
        check({tag, " cnt_bad"},  int'(cnt_bad),  m_bad);
        check({tag, " cnt_lost"}, int'(cnt_lost), m_lost);
        check({tag, " cnt_rep"},  int'(cnt_rep),  m_rep);
        check({tag, " act_b"},    int'(act_b),    m_act);
        check({tag, " code"},     int'(code),     m_code);
        check({tag, " frm_tmo"},  int'(frm_tmo),  ftmo);
        check({tag, " nrg_tmo"},  int'(nrg_tmo),  ntmo);
    endtask

    task automatic drive(input logic [31:0] fa, input logic [31:0] fb,
                         input bit ea, input bit eb, input int gap);
        a_vld = 0; b_vld = 0;
        repeat (gap) @(negedge clk);
        for (int i = 31; i >= 0; i--) begin
            a_vld = ea; a_sof = (i == 31); a_dat = fa[i];
            b_vld = eb; b_sof = (i == 31); b_dat = fb[i];
            @(negedge clk);
        end
        a_vld = 0; b_vld = 0; a_sof = 0; b_sof = 0;
    endtask

    // good frame on both feeds carrying a new value
    task automatic send_new(input logic [15:0] e, input logic t, input int gap);
        m_code = test_mode ? int'(test_code) : ref_code(e);
        m_good++;
        exp_q.push_back(mk_tx(m_code, t));
        drive(mk(e, t), mk(e, t), 1, 1, gap);
    endtask

    // scoreboard monitor
    logic [31:0] got = '0;
    int nb = 0;
    always @(negedge clk) begin
        if (rst_n && tx_vld) begin
            if (tx_sof) nb = 0;
            checks++;
            if (tx_dat != {N_RX{tx_dat[0]}}) begin
                fails++;
                $display("FAIL R10 lanes differ actual=%0h expected=%0h", tx_dat, {N_RX{tx_dat[0]}});
            end
            got = {got[30:0], tx_dat[0]};
            nb++;
            if (nb == 32) begin
                nb = 0;
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R10 unexpected frame actual=%08h expected=none", got);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    if (got != e) begin
                        fails++;
                        $display("FAIL R10 frame actual=%08h expected=%08h", got, e);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] f;
        repeat (5) @(negedge clk);
        // R11 reset state
        check_all("R11 reset", 0, 0);
        check("R11 tx_vld", int'(tx_vld), 0);
        rst_n = 1'b1;

        // R3 R4 R10 basic conversions, including table boundaries
        send_new(16'h1234, 1'b1, 0); check_all("R4 mid", 0, 0);
        send_new(16'hFFFF, 1'b0, 2); check_all("R4 top", 0, 0);
        send_new(16'h0000, 1'b1, 2); check_all("R4 zero", 0, 0);
        send_new(16'h0040, 1'b0, 2); check_all("R4 step", 0, 0);
        send_new(16'h003F, 1'b1, 2); check_all("R4 below", 0, 0);

        // R6 repeated toggle: no update, no frame
        m_good++; m_rep++;
        drive(mk(16'h8000, 1'b1), mk(16'h8000, 1'b1), 1, 1, 2);
        check_all("R6 repeat", 0, 0);

        // R5 test substitution
        test_mode = 1'b1; test_code = 5'h15; test_cmd = 11'h0F1;
        send_new(16'h1000, 1'b0, 2); check_all("R5 subst", 0, 0);
        test_mode = 1'b0;

        // R2 bad CRC on active A, B ignored as standby
        f = mk(16'h2222, 1'b1); f[0] = ~f[0];
        m_bad++; m_act = 1;
        drive(f, mk(16'h2222, 1'b1), 1, 1, 2);
        check_all("R2 crc", 0, 0);

        // R9 R1 bad header on standby A is ignored; B good
        f = mk(16'h2000, 1'b1); f[31] = 1'b0;
        m_code = ref_code(16'h2000); m_good++;
        exp_q.push_back(mk_tx(m_code, 1'b1));
        drive(f, mk(16'h2000, 1'b1), 1, 1, 2);
        check_all("R9 standby", 0, 0);

        // R1 R2 nonzero pad bits on active B
        f = mk(16'h3000, 1'b0); f[6] = 1'b1;
        m_bad++; m_act = 0;
        drive(mk(16'h3000, 1'b0), f, 1, 1, 2);
        check_all("R1 pad", 0, 0);

        // R7 frame completing on the expiry cycle wins
        send_new(16'h3000, 1'b0, 8); check_all("R7 tie", 0, 0);

        // R7 one cycle late: timeout, feed change, late A frame ignored
        m_lost++; m_act = 1;
        drive(mk(16'h4000, 1'b1), mk(16'h4000, 1'b1), 1, 0, 9);
        check_all("R7 expire", 1, 0);
        send_new(16'h4000, 1'b1, 0); check_all("R7 clear", 0, 0);

        // R8 stale value under repeated toggles
        for (int i = 0; i < 5; i++) begin
            m_good++; m_rep++;
            drive(mk(16'h5000, 1'b1), mk(16'h5000, 1'b1), 1, 1, 2);
        end
        check_all("R8 before", 0, 0);
        for (int i = 0; i < 2; i++) begin
            m_good++; m_rep++;
            drive(mk(16'h5000, 1'b1), mk(16'h5000, 1'b1), 1, 1, 2);
        end
        check_all("R8 stale", 0, 1);
        send_new(16'h5000, 1'b0, 2); check_all("R8 fresh", 0, 0);

        repeat (40) @(negedge clk);
        check("R10 pending frames", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule